// File: doc/BRIEF.md
# DRAM Parallel Compare Self-Test Sequencer

This block drives the strobe, address and data pins of a page-mode DRAM to run a self-test through the memory's built-in parallel compare mode. After `start`, it latches the device into compare mode with a CAS-before-RAS cycle that has write enable held low. It then makes two passes over the compressed address space: all zeros first, then all ones. Each pass writes every compressed location and then reads every location back. In compare mode one access covers eight internal cells. A data pin that reads high means those eight cells agree, and a low pin means they disagree.

A read that returns any low pin marks the test as failed. The index of the first failing location is kept. The sequencer always completes all four sweeps. It then leaves compare mode with a CAS-before-RAS cycle that has write enable high, and raises `done`. Strobe widths are parameters counted in clock cycles. Read accesses hold CAS low for `T_EXTRA` cycles longer than writes, which covers the longer access time of compare-mode reads.

Top module: `dram_ptest_top`

## Requirements
- R1: After reset, `rasN`, `casN` and `weN` are high, `dqOe` is low and `done` is low.
- R2: The first DRAM cycle after `start` is a CAS-before-RAS cycle. In it, `casN` falls at least one clock before `rasN`, and `weN` stays low from the fall of `casN` until `rasN` rises. This latches compare mode.
- R3: Each pass writes every compressed location exactly once, in ascending index order, with all data pins driving the pass pattern and `dqOe` high. The first pass uses all zeros and the second uses all ones. The row address is the upper `ROW_BITS` of the index, with address bit 10 low. The column address is the lower `COL_BITS` of the index shifted up by one, with address bits 0 and 10 low.
- R4: After each write sweep comes a read sweep over the same locations in the same order, with `weN` high and `dqOe` low. The data pins are sampled at the end of a CAS-low window of `T_CAS + T_EXTRA` cycles.
- R5: If any data pin samples low in any read, `pass` is low at `done`. Otherwise `pass` is high.
- R6: `failAddr` holds the index {row, column} of the first read that failed, in execution order: the zeros read sweep before the ones read sweep, and ascending index within a sweep. Later failures do not change it.
- R7: After the last read, the sequencer runs a CAS-before-RAS cycle with `weN` high, which clears compare mode, and only then raises `done`. This happens whether or not a failure was seen.
- R8: `done` stays high until the next `start`. A `start` pulse while a test is running has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a test (acted on only when idle or done) |
| dqIn | input | DQ_W | Data pins as read from the DRAM |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Multiplexed row/column address |
| dqOut | output | DQ_W | Write data |
| dqOe | output | 1 | Write data drive enable |
| done | output | 1 | Test complete and compare mode exited |
| pass | output | 1 | No failing read seen |
| failAddr | output | ROW_BITS+COL_BITS | Index of the first failing location |

## Verification
A wrong state or phase shows up at the pins within one DRAM cycle. Examples are a missed mode entry, writes issued outside compare mode, a wrong pattern, or an address that skips or repeats. The bench's memory model then either flags the access directly or stores cells that disagree. Disagreeing cells turn every later compare read low, so `pass` and `failAddr` are wrong by the time `done` rises. A read window that is too short is caught in the first read. The model only returns valid compare data after the lengthened CAS-low time, so the sampled pins read low.

// File: rtl/dram_ptest_pkg.sv
package dram_ptest_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RCAS, S_RRAS, S_ROW, S_COL, S_PRE, S_DONE
  } ptState_t;

  typedef enum logic [1:0] {
    P_ENTER, P_WRITE, P_READ, P_EXIT
  } ptPhase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrAll;   // restart: index 0, pattern 0, failure cleared
    logic idxInc;   // advance to next compressed location
    logic patLoad;  // switch pattern to all ones
    logic selCol;   // drive column half of the address
    logic sample;   // capture compare result from data pins
  } ptStrobe_t;

endpackage

// File: rtl/ptest_datapath.sv
module ptest_datapath
  import dram_ptest_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DQ_W     = 8,
  parameter int ROW_BITS = 10,
  parameter int COL_BITS = 9
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ptStrobe_t                    strb,
  input  logic [DQ_W-1:0]              dqIn,
  output logic [ADDR_W-1:0]            addr,
  output logic [DQ_W-1:0]              dqOut,
  output logic                         lastIdx,
  output logic                         patOne,
  output logic                         passOk,
  output logic [ROW_BITS+COL_BITS-1:0] failAddr
);
  localparam int IDX_W = ROW_BITS + COL_BITS;

  logic [IDX_W-1:0]    idx;
  logic                failSeen;
  logic [COL_BITS-1:0] colPart;
  logic [ROW_BITS-1:0] rowPart;
  logic                anyLow;

  assign colPart = idx[COL_BITS-1:0];
  assign rowPart = idx[IDX_W-1:COL_BITS];
  assign anyLow  = (dqIn != {DQ_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx      <= '0;
      patOne   <= 1'b0;
      failSeen <= 1'b0;
      failAddr <= '0;
    end else begin
      if (strb.clrAll) begin
        idx      <= '0;
        patOne   <= 1'b0;
        failSeen <= 1'b0;
        failAddr <= '0;
      end else begin
        if (strb.idxInc)  idx    <= idx + 1'b1;
        if (strb.patLoad) patOne <= 1'b1;
        if (strb.sample && anyLow && !failSeen) begin
          failSeen <= 1'b1;
          failAddr <= idx;
        end
      end
    end
  end

  // ignored compare-mode bits (row 10, column 0 and 10) are driven low
  assign addr    = strb.selCol ? ADDR_W'({colPart, 1'b0}) : ADDR_W'(rowPart);
  assign dqOut   = {DQ_W{patOne}};
  assign lastIdx = &idx;
  assign passOk  = !failSeen;

  // R6
  first_fail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    failSeen && !strb.clrAll |=> $stable(failAddr));

  // R5
  fail_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample && anyLow && !strb.clrAll |=> !passOk);

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.idxInc && !strb.clrAll |=> idx == $past(idx) + 1'b1);

endmodule

// File: rtl/ptest_control.sv
module ptest_control
  import dram_ptest_pkg::*;
#(
  parameter int T_CSR   = 1,
  parameter int T_RAS   = 6,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_EXTRA = 1,
  parameter int T_RP    = 4,
  parameter int TMR_W   = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      lastIdx,
  input  logic      patOne,
  output logic      rasN,
  output logic      casN,
  output logic      weN,
  output logic      dqOe,
  output logic      done,
  output ptStrobe_t strb
);
  localparam int T_RD = T_CAS + T_EXTRA;

  ptState_t         state, nxt;
  ptPhase_t         phase, phaseNxt;
  logic [TMR_W-1:0] tmr;
  logic             tmrZero;

  assign tmrZero = (tmr == '0);

  function automatic logic [TMR_W-1:0] durOf(ptState_t s, ptPhase_t p);
    case (s)
      S_RCAS:  return TMR_W'(T_CSR - 1);
      S_RRAS:  return TMR_W'(T_RAS - 1);
      S_ROW:   return TMR_W'(T_RCD - 1);
      S_COL:   return (p == P_READ) ? TMR_W'(T_RD - 1) : TMR_W'(T_CAS - 1);
      S_PRE:   return TMR_W'(T_RP - 1);
      default: return '0;
    endcase
  endfunction

  always_comb begin
    nxt      = state;
    phaseNxt = phase;
    strb     = '0;
    strb.selCol = (state == S_COL);
    case (state)
      S_IDLE, S_DONE: if (start) begin
        strb.clrAll = 1'b1;
        phaseNxt    = P_ENTER;
        nxt         = S_RCAS;
      end
      S_RCAS: if (tmrZero) nxt = S_RRAS;
      S_RRAS: if (tmrZero) nxt = S_PRE;
      S_ROW:  if (tmrZero) nxt = S_COL;
      S_COL:  if (tmrZero) begin
        strb.sample = (phase == P_READ);
        nxt         = S_PRE;
      end
      S_PRE: if (tmrZero) begin
        case (phase)
          P_ENTER: begin phaseNxt = P_WRITE; nxt = S_ROW; end
          P_EXIT:  nxt = S_DONE;
          default: begin
            strb.idxInc = 1'b1;          // wraps to 0 after the last index
            nxt         = S_ROW;
            if (lastIdx) begin
              if (phase == P_WRITE) phaseNxt = P_READ;
              else if (!patOne) begin
                strb.patLoad = 1'b1;
                phaseNxt     = P_WRITE;
              end else begin
                phaseNxt = P_EXIT;
                nxt      = S_RCAS;
              end
            end
          end
        endcase
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= P_ENTER;
      tmr   <= '0;
    end else begin
      state <= nxt;
      phase <= phaseNxt;
      if (nxt != state)  tmr <= durOf(nxt, phaseNxt);
      else if (!tmrZero) tmr <= tmr - 1'b1;
    end
  end

  assign rasN = !(state == S_RRAS || state == S_ROW || state == S_COL);
  assign casN = !(state == S_RCAS || state == S_RRAS || state == S_COL);
  assign weN  = !(((state == S_RCAS || state == S_RRAS) && phase == P_ENTER) ||
                  (state == S_COL && phase == P_WRITE));
  assign dqOe = (state == S_COL) && (phase == P_WRITE);
  assign done = (state == S_DONE);

  // R2
  cbr_cas_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) && !casN |-> $past(!casN));

  // R2
  entry_we_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rasN && !casN && !weN && !dqOe |=> rasN || !weN);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done && state != S_IDLE && start |=> !done);

  // R3
  drive_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !weN && !casN && !rasN);

endmodule

// File: rtl/dram_ptest_top.sv
module dram_ptest_top
  import dram_ptest_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DQ_W     = 8,
  parameter int ROW_BITS = 10,
  parameter int COL_BITS = 9,
  parameter int T_CSR    = 1,
  parameter int T_RAS    = 6,
  parameter int T_RCD    = 2,
  parameter int T_CAS    = 2,
  parameter int T_EXTRA  = 1,
  parameter int T_RP     = 4,
  parameter int TMR_W    = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [DQ_W-1:0]              dqIn,
  output logic                         rasN,
  output logic                         casN,
  output logic                         weN,
  output logic [ADDR_W-1:0]            addr,
  output logic [DQ_W-1:0]              dqOut,
  output logic                         dqOe,
  output logic                         done,
  output logic                         pass,
  output logic [ROW_BITS+COL_BITS-1:0] failAddr
);
  ptStrobe_t strb;
  logic      lastIdx;
  logic      patOne;

  ptest_control #(
    .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_EXTRA(T_EXTRA), .T_RP(T_RP), .TMR_W(TMR_W)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .start(start), .lastIdx(lastIdx), .patOne(patOne),
    .rasN(rasN), .casN(casN), .weN(weN), .dqOe(dqOe), .done(done), .strb(strb)
  );

  ptest_datapath #(
    .ADDR_W(ADDR_W), .DQ_W(DQ_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dqIn(dqIn), .addr(addr),
    .dqOut(dqOut), .lastIdx(lastIdx), .patOne(patOne), .passOk(pass),
    .failAddr(failAddr)
  );

endmodule

// File: tb/test_dram_ptest_top.sv
module test_dram_ptest_top;
  localparam int RB = 2, CB = 2, N = 16, IW = RB + CB;
  localparam int T_CAS = 2, T_EXTRA = 1;
  localparam int RD_LAT = T_CAS + T_EXTRA - 1;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [7:0] dqIn, dqOut;
  logic rasN, casN, weN, dqOe, done, pass;
  logic [10:0] addr;
  logic [IW-1:0] failAddr;

  always #4 clk = ~clk;

  dram_ptest_top #(.ROW_BITS(RB), .COL_BITS(CB), .T_CAS(T_CAS), .T_EXTRA(T_EXTRA))
  i_dram_ptest_top (
    .clk(clk), .rstN(rstN), .start(start), .dqIn(dqIn), .rasN(rasN), .casN(casN),
    .weN(weN), .addr(addr), .dqOut(dqOut), .dqOe(dqOe), .done(done), .pass(pass),
    .failAddr(failAddr));

  // ---------------- DRAM model ----------------
  logic [7:0] cells [N][8];
  logic       fEn [2];
  int         fAddr [2], fPin [2], fCell [2];
  logic       fVal [2];
  logic clrModel = 1'b0;
  logic prevRas = 1'b1, prevCas = 1'b1, cbr = 1'b0, casSeen = 1'b0, testMode = 1'b0;
  logic [RB-1:0] rowL = '0;
  int casCnt = 0, wrCnt = 0, rdCnt = 0, entries = 0;
  int badAddr = 0, modeErr = 0, patErr = 0, orderErr = 0;
  int compared = 0, mismatched = 0;

  function automatic logic [7:0] compareOut(int idx);
    logic [7:0] r;
    for (int p = 0; p < 8; p++) begin
      logic [7:0] v = cells[idx][p];
      for (int f = 0; f < 2; f++)
        if (fEn[f] && fAddr[f] == idx && fPin[f] == p) v[fCell[f]] = fVal[f];
      r[p] = testMode ? (v == 8'h00 || v == 8'hFF) : v[0];
    end
    return r;
  endfunction

  always_comb begin
    if (!rasN && !casN && weN && casCnt >= RD_LAT)
      dqIn = compareOut(int'({rowL, addr[CB:1]}));
    else
      dqIn = 8'h00;
  end

  always @(posedge clk) begin
    int idx;
    prevRas <= rasN;
    prevCas <= casN;
    casCnt  <= (!rasN && !casN) ? casCnt + 1 : 0;
    if (clrModel) begin
      wrCnt <= 0; rdCnt <= 0; entries <= 0; badAddr <= 0;
      modeErr <= 0; patErr <= 0; orderErr <= 0;
    end else begin
      if (prevRas && !rasN) begin
        casSeen <= 1'b0;
        if (!casN) begin
          cbr <= 1'b1;
          testMode <= !weN;
          if (!weN) entries <= entries + 1;
        end else begin
          cbr <= 1'b0;
          rowL <= addr[RB-1:0];
          if (addr[10:RB] != '0) badAddr <= badAddr + 1;
        end
      end
      if (!prevRas && rasN && !cbr && !casSeen) testMode <= 1'b0;
      if (prevCas && !casN && !rasN) begin
        casSeen <= 1'b1;
        idx = int'({rowL, addr[CB:1]});
        if (addr[0] || addr[10:CB+1] != '0) badAddr <= badAddr + 1;
        if (!testMode) modeErr <= modeErr + 1;
        if (!weN) begin
          if (!dqOe || dqOut != {8{wrCnt >= N}}) patErr <= patErr + 1;
          if (idx != wrCnt % N) orderErr <= orderErr + 1;
          for (int p = 0; p < 8; p++)
            cells[idx][p] <= testMode ? {8{dqOut[p]}} : {cells[idx][p][7:1], dqOut[p]};
          wrCnt <= wrCnt + 1;
        end else begin
          if (dqOe) patErr <= patErr + 1;
          if (idx != rdCnt % N) orderErr <= orderErr + 1;
          rdCnt <= rdCnt + 1;
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input logic ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expectFirst();
    int best = -1;
    for (int pat = 1; pat >= 0; pat--) begin   // stuck-at-1 fails in zeros pass first
      for (int f = 0; f < 2; f++)
        if (fEn[f] && fVal[f] == pat[0] && (best < 0 || fAddr[f] < best)) best = fAddr[f];
      if (best >= 0) return best;
    end
    return -1;
  endfunction

  task automatic runOne(input int midStart);
    int cyc = 0, exp;
    for (int a = 0; a < N; a++)
      for (int p = 0; p < 8; p++) cells[a][p] = 8'($urandom);
    @(negedge clk); clrModel = 1'b1;
    @(negedge clk); clrModel = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done, "R8 done drops on start", done, 0);
    while (!done && cyc < 5000) begin
      @(negedge clk); cyc++;
      if (cyc == midStart) start = 1'b1; else start = 1'b0;
    end
    start = 1'b0;
    check(cyc < 5000, "R7 watchdog", cyc, 5000);
    exp = expectFirst();
    check(!testMode, "R7 compare mode cleared", testMode, 0);
    check(entries == 1, "R2 single mode entry", entries, 1);
    check(modeErr == 0, "R2 accesses inside compare mode", modeErr, 0);
    check(wrCnt == 2 * N && patErr == 0, "R3 write sweeps", wrCnt, 2 * N);
    check(badAddr == 0 && orderErr == 0, "R3 address order/format", badAddr + orderErr, 0);
    check(rdCnt == 2 * N, "R4 read sweeps", rdCnt, 2 * N);
    check(pass == (exp < 0), "R5 pass flag", pass, exp < 0);
    if (exp >= 0) check(int'(failAddr) == exp, "R6 first failing index", failAddr, exp);
    repeat (20) @(negedge clk);
    check(done, "R8 done held", done, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fEn[0] = 0; fEn[1] = 0;
    fAddr[0] = 0; fAddr[1] = 0; fPin[0] = 0; fPin[1] = 0;
    fCell[0] = 0; fCell[1] = 0; fVal[0] = 0; fVal[1] = 0;
    repeat (3) @(negedge clk);
    check(rasN && casN && weN && !dqOe && !done, "R1 reset state",
          {rasN, casN, weN, dqOe, done}, 5'b11100);
    rstN = 1'b1;
    @(negedge clk);
    // directed: clean memory
    runOne(0);
    // directed: stuck-at-1 at last index
    fEn[0] = 1; fAddr[0] = N - 1; fPin[0] = 7; fCell[0] = 5; fVal[0] = 1;
    runOne(0);
    // directed: stuck-at-0 earlier, stuck-at-1 later -> later one fails first
    fEn[1] = 1; fAddr[1] = 0; fPin[1] = 0; fCell[1] = 0; fVal[1] = 0;
    runOne(300);
    // random
    for (int r = 0; r < 10; r++) begin
      for (int f = 0; f < 2; f++) begin
        fEn[f] = 1'($urandom_range(0, 1));
        fAddr[f] = $urandom_range(0, N - 1);
        fPin[f] = $urandom_range(0, 7);
        fCell[f] = $urandom_range(0, 7);
        fVal[f] = 1'($urandom_range(0, 1));
      end
      runOne($urandom_range(0, 400));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R7 global watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule